// File: doc/BRIEF.md
# Bit-Serial Signed Shift-Accumulate Multiplier

This block multiplies a two's-complement word, presented in parallel, by a two's-complement operand that arrives one bit per clock with the least significant bit first. The product leaves serially, LSB first, at the same one-bit-per-clock rate. A single-cycle pulse on `start_i` marks the first serial bit and loads the parallel word. After `S_W` serial bits the block stops using the serial input and repeats the captured sign bit internally. It keeps running until `P_W + S_W - 1` product bits have been produced.

The datapath is a chain of `P_W` identical bit cells. Each cell gates its parallel-operand bit with the current serial bit. It then adds that partial product to the sum delayed in its more-significant neighbour and to its own stored carry. The cell for the sign position inverts its partial product, and a one-cycle bias enters the top of the chain on the start cycle. Together these absorb the negative weight of the parallel word's sign bit, so no correction pass is needed. The start cycle also clears every sum and carry flop, so products can follow one another with no idle cycle.

Top module: `smul_serial`

## Requirements
- R1: With N = P_W + S_W - 1, `valid_o` is high in the N cycles that follow the N clock edges of a product. Bit k of the product is on `prod_o` in the cycle after the edge at which serial bit k (k = 0 on the `start_i` edge) is taken.
- R2: The N output bits equal the two's-complement product of the parallel and serial operands modulo 2^N. This is the exact product for every operand pair except the one where both operands are most negative.
- R3: On cycles S_W to N-1 of a product, `ser_i` is ignored. The serial operand's bit S_W-1 is used as its sign in its place.
- R4: `par_i` is sampled only on the cycle where `start_i` is high. Changes at any other time have no effect on the product.
- R5: Every sum and carry flop is cleared by `start_i`. A product started on the cycle right after the previous one's last bit is independent of that previous product.
- R6: `done_o` is high for exactly one cycle per product, together with the product's last bit, while `valid_o` is high.
- R7: A `start_i` pulse during a product abandons that product. A new product starts from that edge.
- R8: While no product is running, `ser_i` and `par_i` have no effect, and `valid_o`, `done_o` and `prod_o` stay low.
- R9: While `rst_ni` is low, and until the first `start_i`, `valid_o`, `done_o` and `prod_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Active-high pulse marking the first serial bit and loading `par_i` |
| ser_i | input | 1 | Serial operand, two's complement, LSB first |
| par_i | input | P_W | Parallel operand, two's complement |
| prod_o | output | 1 | Serial product bit, LSB first |
| valid_o | output | 1 | `prod_o` carries a product bit |
| done_o | output | 1 | Last product bit is on `prod_o` |

## Verification
The bench builds the block with a 5-bit parallel operand and a 4-bit serial operand, giving 8-bit products. At that size every one of the 512 operand pairs can be run back to back and compared with an integer multiply. This covers both most-negative operands, the worked fraction example 1,1101 times 1,001, and the chaining of each product directly onto the previous one. During sign extension the bench drives the inverse of the sign bit on `ser_i`, and after the start cycle it drives random words on `par_i`. Any leak of either input into the product therefore shows up in the result. Separate sequences cover an aborted product followed by a restart, and idle cycles with active inputs.

// File: rtl/smul_pkg.sv
package smul_pkg;

  function automatic int prod_len(int p_w, int s_w);
    return p_w + s_w - 1;
  endfunction

  function automatic int cnt_width(int n);
    return $clog2(n + 1);
  endfunction

endpackage

// File: rtl/smul_ctrl.sv
module smul_ctrl #(
  parameter int P_W = 16,
  parameter int S_W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic ser_i,
  output logic run_o,
  output logic xbit_o,
  output logic valid_o,
  output logic done_o
);
  localparam int N  = smul_pkg::prod_len(P_W, S_W);
  localparam int CW = smul_pkg::cnt_width(N);

  logic          busy_q, sign_q, valid_q, done_q;
  logic [CW-1:0] cnt_q, t_cur;
  logic          last;

  assign t_cur  = start_i ? '0 : cnt_q;
  assign run_o  = start_i | busy_q;
  assign last   = (t_cur == CW'(N - 1));
  // past the serial word, repeat its sign bit
  assign xbit_o = (t_cur < CW'(S_W)) ? ser_i : sign_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      sign_q  <= 1'b0;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      if (start_i) begin
        cnt_q  <= CW'(1);
        busy_q <= !last;
      end else if (busy_q) begin
        cnt_q  <= cnt_q + CW'(1);
        busy_q <= !last;
      end
      if (run_o && t_cur == CW'(S_W - 1)) sign_q <= ser_i;
      valid_q <= run_o;
      done_q  <= run_o & last;
    end
  end

  assign valid_o = valid_q;
  assign done_o  = done_q;

  p_cnt_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(N));
  p_done_in_valid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> valid_o);
  p_valid_runs_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !done_o) |=> valid_o);
  p_valid_needs_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(start_i));
  p_sign_frozen_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !start_i && cnt_q >= CW'(S_W)) |=> $stable(sign_q));

endmodule

// File: rtl/smul_cell.sv
module smul_cell #(
  parameter bit IS_TOP = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clr_i,
  input  logic a_i,
  input  logic x_i,
  input  logic s_up_i,
  output logic s_o
);
  logic s_q, c_q;
  logic pp, s_in, c_in, sum, cout;

  // sign position carries negative weight: inverted partial product,
  // the constant it owes enters as a bias on the clearing cycle
  assign pp   = IS_TOP ? ~(a_i & x_i) : (a_i & x_i);
  assign s_in = clr_i ? IS_TOP : s_up_i;
  assign c_in = clr_i ? 1'b0 : c_q;
  assign {cout, sum} = {1'b0, pp} + {1'b0, s_in} + {1'b0, c_in};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_q <= 1'b0;
      c_q <= 1'b0;
    end else if (en_i) begin
      s_q <= sum;
      c_q <= cout;
    end
  end

  assign s_o = s_q;

  p_hold_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(s_q) && $stable(c_q)));

endmodule

// File: rtl/smul_array.sv
module smul_array #(
  parameter int P_W = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic           clr_i,
  input  logic [P_W-1:0] a_i,
  input  logic           x_i,
  output logic           p_o
);
  logic [P_W:0] s_chain;

  assign s_chain[P_W] = 1'b0;

  for (genvar i = 0; i < P_W; i++) begin : g_cell
    smul_cell #(
      .IS_TOP(i == P_W - 1)
    ) u_cell (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (en_i),
      .clr_i (clr_i),
      .a_i   (a_i[i]),
      .x_i   (x_i),
      .s_up_i(s_chain[i+1]),
      .s_o   (s_chain[i])
    );
  end

  assign p_o = s_chain[0];

endmodule

// File: rtl/smul_serial.sv
module smul_serial #(
  parameter int P_W = 16,
  parameter int S_W = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           ser_i,
  input  logic [P_W-1:0] par_i,
  output logic           prod_o,
  output logic           valid_o,
  output logic           done_o
);
  logic [P_W-1:0] par_q, a_cur;
  logic           run, xbit, p_raw;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      par_q <= '0;
    else if (start_i) par_q <= par_i;
  end

  assign a_cur = start_i ? par_i : par_q;

  smul_ctrl #(
    .P_W(P_W),
    .S_W(S_W)
  ) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .ser_i  (ser_i),
    .run_o  (run),
    .xbit_o (xbit),
    .valid_o(valid_o),
    .done_o (done_o)
  );

  smul_array #(
    .P_W(P_W)
  ) u_array (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (run),
    .clr_i (start_i),
    .a_i   (a_cur),
    .x_i   (xbit),
    .p_o   (p_raw)
  );

  assign prod_o = p_raw & valid_o;

  p_par_kept_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(par_q));

endmodule

// File: tb/smul_serial_tb.sv
module smul_serial_tb;
  localparam int CLK_PERIOD = 10;
  localparam int P_W = 5;
  localparam int S_W = 4;
  localparam int N   = P_W + S_W - 1;

  logic           clk = 1'b0;
  logic           rst_ni = 1'b0;
  logic           start = 1'b0;
  logic           ser = 1'b0;
  logic [P_W-1:0] par = '0;
  logic           prod, valid, done;
  int             n_chk = 0;
  int             n_err = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  smul_serial #(.P_W(P_W), .S_W(S_W)) u_dut (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .start_i(start),
    .ser_i  (ser),
    .par_i  (par),
    .prod_o (prod),
    .valid_o(valid),
    .done_o (done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  // full product; extension cycles carry the inverted sign, par is junk after start
  task automatic mul(input logic [P_W-1:0] a, input logic [S_W-1:0] x, input string req);
    logic [N-1:0] got, exp_bits;
    int av, xv;
    bit flags_ok;
    flags_ok = 1'b1;
    for (int t = 0; t < N; t++) begin
      start = (t == 0);
      par   = (t == 0) ? a : P_W'($urandom);
      ser   = (t < S_W) ? x[t] : ~x[S_W-1];
      @(posedge clk);
      @(negedge clk);
      got[t] = prod;
      if (!valid || done != (t == N - 1)) flags_ok = 1'b0;
    end
    start = 1'b0;
    av = int'(a); if (a[P_W-1]) av -= (1 << P_W);
    xv = int'(x); if (x[S_W-1]) xv -= (1 << S_W);
    exp_bits = N'(av * xv);
    chk(got == exp_bits, req, int'(got), int'(exp_bits));
    chk(flags_ok, "R1/R6 valid and done framing", int'(flags_ok), 1);
  endtask

  task automatic partial(input logic [P_W-1:0] a, input logic [S_W-1:0] x, input int cyc);
    for (int t = 0; t < cyc; t++) begin
      start = (t == 0);
      par   = a;
      ser   = x[t % S_W];
      @(posedge clk);
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  task automatic idle(input int cyc);
    for (int t = 0; t < cyc; t++) begin
      start = 1'b0;
      ser   = 1'($urandom);
      par   = P_W'($urandom);
      @(posedge clk);
      @(negedge clk);
      chk(!valid && !done && !prod, "R8 idle outputs low",
          int'({valid, done, prod}), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    n_chk++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!valid && !done && !prod, "R9 outputs in reset", int'({valid, done, prod}), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!valid && !done && !prod, "R9 outputs after reset", int'({valid, done, prod}), 0);

    // fraction example: 1,1101 x 1,001 -> 0,0010101
    mul(5'b11101, 4'b1001, "R2 worked example");
    // both most negative: only the modulo result is defined
    mul(5'b10000, 4'b1000, "R2 most-negative pair");

    // every pair, back to back (R5 independence, R3/R4 junk inputs)
    for (int a = 0; a < (1 << P_W); a++) begin
      for (int x = 0; x < (1 << S_W); x++) begin
        mul(P_W'(a), S_W'(x), "R2/R3/R4/R5 sweep");
      end
    end

    idle(6);

    // abort mid-product, then restart
    partial(5'b01111, 4'b0111, 3);
    mul(5'b10011, 4'b1101, "R7 restart after abort");
    partial(5'b11111, 4'b1111, 7);
    mul(5'b00001, 4'b0111, "R7 restart on last cycle");

    idle(4);
    mul(5'b01111, 4'b0111, "R2 largest positive pair");
    idle(3);

    summary();
    $finish;
  end

endmodule